// File: doc/BRIEF.md
# Leaky Overcurrent Event Counter

This block watches a half-bridge for repeated overcurrent and decides when the problem is persistent enough to shut the stage down. Each low-side switching period is treated as one sample. The period counts as an overcurrent period only if the current comparator reported a fault while the low-side gate was on. Periods with an overcurrent move a saturating count up by one. Clean periods move it down by one. Isolated noise pulses therefore decay away, while a sustained fault climbs to a trip level and sets a sticky fault flag.

The mode controller drives an enable. It holds the enable low in the modes where overcurrent is expected, such as lamp ignition, and this keeps the count at zero. The fault flag is only cleared by the synchronous reset, which the controller asserts when it goes back to undervoltage lockout. The comparator, the threshold reference and the mode sequencing are outside the block.

Top module: `oc_fault_counter`

## Requirements
- R1: A switching period counts as overcurrent only if `oc_flag` is sampled high on a clock edge where `lo_drive` is also high. `oc_flag` sampled while `lo_drive` is low has no effect on the count.
- R2: A switching period ends at the first clock edge where `lo_drive` is sampled low after being sampled high. At that edge `oc_count` rises by one if the period was an overcurrent period.
- R3: At the end of a clean period `oc_count` falls by one. It never goes below zero.
- R4: `fault` rises at the same clock edge at which `oc_count` reaches `TRIP_LEVEL` (default 65).
- R5: While `count_en` is sampled low, `oc_count` is zero from the next edge on. Overcurrent seen while it is low is not counted later.
- R6: Once set, `fault` stays high until `rst`. Dropping `count_en` or later clean periods do not clear it.
- R7: If `oc_flag` is held high continuously while `lo_drive` keeps switching, the block trips after `TRIP_LEVEL` periods.
- R8: While `count_en` is high, `oc_count` changes only at the end of a switching period.
- R9: `oc_count` never exceeds `TRIP_LEVEL`.
- R10: A synchronous active-high `rst` sets `oc_count` to zero and `fault` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset (undervoltage lockout) |
| lo_drive | input | 1 | Low-side gate drive, high while the low switch is on |
| oc_flag | input | 1 | Overcurrent comparator output |
| count_en | input | 1 | Counting enable from the mode controller |
| fault | output | 1 | Sticky overcurrent fault |
| oc_count | output | CNT_W (7) | Present event count |

## Verification
Several properties are checked on every clock by the assertions:
- the count moves by at most one step per clock and only at the end of a period;
- the count is cleared when disabled and is bounded by the trip level;
- the sticky bit is cleared after each period end;
- the fault rises exactly at the trip count and then stays high.

Other behaviour can only be shown by the bench's directed scenarios:
- the exact arithmetic of the count over long patterns;
- the masking of flags outside the on-time;
- the decay of alternating noise to zero;
- the trip after exactly 65 periods under a constant flag;
- the persistence of the fault across disable and clean periods.

// File: rtl/oc_fault_pkg.sv
package oc_fault_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_UP,
        STEP_DOWN,
        STEP_CLEAR
    } cnt_step_e;

    typedef struct packed {
        logic period_end;
        logic oc_hit;
    } sw_period_t;

    function automatic cnt_step_e pick_step(input logic en, input sw_period_t p);
        if (!en)
            return STEP_CLEAR;
        else if (!p.period_end)
            return STEP_HOLD;
        else if (p.oc_hit)
            return STEP_UP;
        else
            return STEP_DOWN;
    endfunction

endpackage

// File: rtl/oc_period_sampler.sv
module oc_period_sampler
    import oc_fault_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lo_drive,
    input  logic       oc_flag,
    input  logic       en,
    output sw_period_t period
);

    logic lo_q;
    logic oc_seen;

    always_comb begin
        period.period_end = lo_q & ~lo_drive;
        period.oc_hit     = oc_seen;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= 1'b0;
            oc_seen <= 1'b0;
        end else begin
            lo_q <= lo_drive;
            if (!en || period.period_end)
                oc_seen <= 1'b0;
            else if (lo_drive && oc_flag)
                oc_seen <= 1'b1;
        end
    end

    AST_SEEN_CLEARED: assert property (@(posedge clk) disable iff (rst)
        period.period_end |=> !oc_seen); // R1

    AST_NO_HIT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> !period.oc_hit); // R5

endmodule

// File: rtl/oc_leaky_counter.sv
module oc_leaky_counter
    import oc_fault_pkg::*;
#(
    parameter int CNT_W      = 7,
    parameter int TRIP_LEVEL = 65
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  sw_period_t       period,
    output logic [CNT_W-1:0] cnt,
    output logic             reach_trip
);

    localparam logic [CNT_W-1:0] TRIP_V = CNT_W'(TRIP_LEVEL);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    cnt_step_e        step;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        step = pick_step(en, period);
        unique case (step)
            STEP_CLEAR: cnt_nxt = '0;
            STEP_UP:    cnt_nxt = (cnt == TRIP_V) ? cnt : cnt + ONE_V;
            STEP_DOWN:  cnt_nxt = (cnt == '0) ? cnt : cnt - ONE_V;
            default:    cnt_nxt = cnt;
        endcase
        reach_trip = (step == STEP_UP) && (cnt_nxt == TRIP_V);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end

    AST_CLEAR_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0)); // R5

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        en |=> (cnt == $past(cnt) || cnt == $past(cnt) + ONE_V || cnt == $past(cnt) - ONE_V)); // R2

    AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (en && !period.period_end) |=> $stable(cnt)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= TRIP_V); // R9

endmodule

// File: rtl/oc_fault_latch.sv
module oc_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    output logic fault
);

    always_ff @(posedge clk) begin
        if (rst)
            fault <= 1'b0;
        else if (set_req)
            fault <= 1'b1;
    end

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault); // R6

endmodule

// File: rtl/oc_fault_counter.sv
module oc_fault_counter
    import oc_fault_pkg::*;
#(
    parameter int CNT_W      = 7,
    parameter int TRIP_LEVEL = 65
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lo_drive,
    input  logic             oc_flag,
    input  logic             count_en,
    output logic             fault,
    output logic [CNT_W-1:0] oc_count
);

    localparam logic [CNT_W-1:0] TRIP_V = CNT_W'(TRIP_LEVEL);

    sw_period_t period;
    logic       reach_trip;

    initial begin
        AST_TRIP_FITS: assert (TRIP_LEVEL >= 1 && TRIP_LEVEL < (1 << CNT_W)); // R9
    end

    oc_period_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .lo_drive (lo_drive),
        .oc_flag  (oc_flag),
        .en       (count_en),
        .period   (period)
    );

    oc_leaky_counter #(
        .CNT_W      (CNT_W),
        .TRIP_LEVEL (TRIP_LEVEL)
    ) u_counter (
        .clk        (clk),
        .rst        (rst),
        .en         (count_en),
        .period     (period),
        .cnt        (oc_count),
        .reach_trip (reach_trip)
    );

    oc_fault_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .set_req (reach_trip),
        .fault   (fault)
    );

    AST_FAULT_AT_TRIP: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> (oc_count == TRIP_V)); // R4

endmodule

// File: tb/oc_fault_counter_tb_top.sv
module oc_fault_counter_tb_top;

    localparam int CNT_W = 7;
    localparam int TRIP  = 65;

    logic             clk = 1'b0;
    logic             rst;
    logic             lo_drive;
    logic             oc_flag;
    logic             count_en;
    logic             fault;
    logic [CNT_W-1:0] oc_count;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    bit exp_fault = 1'b0;

    always #2.5 clk = ~clk;

    oc_fault_counter #(.CNT_W(CNT_W), .TRIP_LEVEL(TRIP)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .lo_drive (lo_drive),
        .oc_flag  (oc_flag),
        .count_en (count_en),
        .fault    (fault),
        .oc_count (oc_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One switching period: 3 clocks on, 2 clocks off; updates the model.
    task automatic run_period(input bit oc_on, input bit oc_off);
        lo_drive = 1'b1;
        oc_flag  = oc_on;
        tick(3);
        lo_drive = 1'b0;
        oc_flag  = oc_off;
        tick(2);
        oc_flag = 1'b0;
        if (!count_en)
            exp_cnt = 0;
        else if (oc_on)
            exp_cnt = (exp_cnt < TRIP) ? exp_cnt + 1 : TRIP;
        else
            exp_cnt = (exp_cnt > 0) ? exp_cnt - 1 : 0;
        if (exp_cnt == TRIP && count_en)
            exp_fault = 1'b1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        lo_drive = 1'b0;
        oc_flag = 1'b0;
        count_en = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(1);
        exp_cnt = 0;
        exp_fault = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R10 count after reset", int'(oc_count), 0);
        check("R10 fault after reset", int'(fault), 0);
    endtask

    task automatic t_up_down();
        for (int i = 0; i < 5; i++) run_period(1'b1, 1'b0);
        check("R2 count after 5 oc periods", int'(oc_count), 5);
        for (int i = 0; i < 7; i++) run_period(1'b0, 1'b0);
        check("R3 count saturates at zero", int'(oc_count), 0);
    endtask

    task automatic t_gating();
        for (int i = 0; i < 3; i++) run_period(1'b1, 1'b0);
        run_period(1'b0, 1'b1);
        check("R1 flag during off-time ignored", int'(oc_count), 2);
        // single-clock pulse in the middle of the on-time counts
        lo_drive = 1'b1;
        tick(1);
        oc_flag = 1'b1;
        tick(1);
        oc_flag = 1'b0;
        tick(1);
        check("R8 count stable mid period", int'(oc_count), 2);
        lo_drive = 1'b0;
        tick(2);
        exp_cnt = 3;
        check("R1 short pulse in on-time counted", int'(oc_count), 3);
        for (int i = 0; i < 3; i++) run_period(1'b0, 1'b0);
        check("R3 decays back to zero", int'(oc_count), 0);
    endtask

    task automatic t_enable();
        for (int i = 0; i < 10; i++) run_period(1'b1, 1'b0);
        check("R2 count before disable", int'(oc_count), 10);
        count_en = 1'b0;
        tick(1);
        check("R5 cleared one clock after disable", int'(oc_count), 0);
        for (int i = 0; i < 4; i++) run_period(1'b1, 1'b0);
        check("R5 held at zero while disabled", int'(oc_count), 0);
        // flag seen while disabled, period ends after enable returns
        lo_drive = 1'b1;
        oc_flag = 1'b1;
        tick(2);
        oc_flag = 1'b0;
        count_en = 1'b1;
        tick(1);
        lo_drive = 1'b0;
        tick(2);
        exp_cnt = 0;
        check("R5 disabled-phase flag not counted", int'(oc_count), 0);
    endtask

    task automatic t_trip_dc();
        for (int i = 0; i < TRIP - 1; i++) run_period(1'b1, 1'b1);
        check("R7 count one below trip", int'(oc_count), TRIP - 1);
        check("R4 no fault below trip", int'(fault), 0);
        run_period(1'b1, 1'b1);
        check("R7 count at trip", int'(oc_count), TRIP);
        check("R4 fault at trip", int'(fault), 1);
        for (int i = 0; i < 3; i++) run_period(1'b1, 1'b1);
        check("R9 count capped at trip", int'(oc_count), TRIP);
        for (int i = 0; i < 5; i++) run_period(1'b0, 1'b0);
        check("R3 count falls after trip", int'(oc_count), exp_cnt);
        check("R6 fault held over clean periods", int'(fault), 1);
        count_en = 1'b0;
        tick(2);
        check("R6 fault held while disabled", int'(fault), 1);
        count_en = 1'b1;
        do_reset();
        check("R10 reset clears fault", int'(fault), 0);
    endtask

    task automatic t_alternating();
        for (int i = 0; i < 100; i++) begin
            run_period(1'b1, 1'b0);
            run_period(1'b0, 1'b0);
        end
        check("R3 alternating noise decays", int'(oc_count), exp_cnt);
        check("R3 alternating noise no fault", int'(fault), int'(exp_fault));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_up_down();
        t_gating();
        t_enable();
        t_trip_dc();
        t_alternating();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule